// File: doc/BRIEF.md
# Not-Recently-Used Eviction Victim Selector

This block tracks, for each of a fixed set of page frames, whether the frame has been touched since the last aging tick and whether it has ever been written. When the surrounding memory manager needs to free a frame, it raises a request. One cycle later the block returns a frame index, the class that frame belonged to, and a one-cycle valid pulse.

Each frame's class comes from its two status bits: the touched bit is the high bit and the written bit is the low bit. The block always picks from the lowest class that currently has members. A frame that was neither touched recently nor written is therefore preferred over one that only needs a write-back. That frame is in turn preferred over frames that are in active use. Inside the winning class, the choice is spread across members by a free-running pseudo-random register. The block scans the frames in a circle from a random starting point and takes the first member it finds.

The aging tick wipes every touched bit and leaves the written bits alone. A frame that is never touched again drifts down to class 0 or 1 and becomes a candidate.

Top module: `nru_victim_sel`

## Requirements
- R1: While `rst_n` is low, every touched bit and written bit is cleared. The outputs `victim_valid`, `victim_frame` and `victim_class` are held at 0, and the random register is loaded with 16'hACE1.
- R2: An accepted access (`acc_valid`=1) sets the touched bit of frame `acc_frame`. When `acc_write`=1, the access also sets that frame's written bit. A read access leaves the written bit unchanged.
- R3: A `tick` clears the touched bit of every frame and leaves every written bit unchanged.
- R4: `victim_class` equals 2*touched + written for the returned frame. Class 0 is untouched and clean, 1 is untouched and written, 2 is touched and clean, 3 is touched and written.
- R5: The returned frame belongs to the lowest-numbered class that has at least one member.
- R6: The random register is 16 bits wide and advances on every clock out of reset. It shifts left, and the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. The scan starts at frame index (register value modulo 8, that is, its bits [2:0]), moves upward with wraparound, and returns the first member of the chosen class.
- R7: When an access and a tick occur in the same cycle, the tick acts first, so the accessed frame ends with its touched bit set.
- R8: `victim_valid` is high for exactly the cycle after each cycle with `victim_req` high. `victim_frame` and `victim_class` change only in those cycles and otherwise hold their last value.
- R9: A request is evaluated on the status bits as they stood before any access or tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access to a frame occurs this cycle |
| acc_frame | input | 3 | Index of the accessed frame |
| acc_write | input | 1 | The access is a write |
| tick | input | 1 | Aging tick: clear all touched bits |
| victim_req | input | 1 | Request an eviction victim |
| victim_frame | output | 3 | Chosen frame index |
| victim_class | output | 2 | Class of the chosen frame |
| victim_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The selector is tried with several status patterns:
- All frames in class 0 after reset, where only the random start decides the frame.
- Only touched frames with a single written one, which separates the touched and written bits.
- All frames written and then aged, which leaves class 1 as the floor.
- A single frame left in a lower class among many in class 3, whose frame must win whatever the random start is.

Further directed cases cover:
- An access and a tick in the same cycle, which tells the required ordering apart from the reverse ordering.
- A request in the same cycle as an access to the would-be victim, which shows whether the pre-access state is used.
- Back-to-back requests.

A long stretch of random accesses, ticks and requests is then compared cycle by cycle against a behavioural model. This catches errors in the scan start, the wraparound and the random sequence.

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int          NFRAMES   = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         IW        = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [IW-1:0] acc_frame,
  input  logic          acc_write,
  input  logic          tick,
  input  logic          victim_req,
  output logic [IW-1:0] victim_frame,
  output logic [1:0]    victim_class,
  output logic          victim_valid
);

  logic [NFRAMES-1:0] ref_q, mod_q, ref_d, mod_d;
  logic [15:0]        lfsr_q;
  logic [NFRAMES-1:0] cls0, cls1, cls2, cls3, cand;
  logic [1:0]         low_cls;
  logic [IW-1:0]      pick;
  logic [15:0]        start_w;

  wire lfsr_fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  assign cls0    = ~ref_q & ~mod_q;
  assign cls1    = ~ref_q &  mod_q;
  assign cls2    =  ref_q & ~mod_q;
  assign cls3    =  ref_q &  mod_q;
  assign start_w = lfsr_q % 16'(NFRAMES);

  always_comb begin
    if (|cls0)      begin low_cls = 2'd0; cand = cls0; end
    else if (|cls1) begin low_cls = 2'd1; cand = cls1; end
    else if (|cls2) begin low_cls = 2'd2; cand = cls2; end
    else            begin low_cls = 2'd3; cand = cls3; end
  end

  always_comb begin
    int s;
    pick = '0;
    for (int k = NFRAMES - 1; k >= 0; k--) begin
      s = int'(start_w) + k;
      if (s >= NFRAMES) s = s - NFRAMES;
      if (cand[s]) pick = IW'(s);
    end
  end

  always_comb begin
    ref_d = tick ? '0 : ref_q;
    mod_d = mod_q;
    if (acc_valid) begin
      ref_d[acc_frame] = 1'b1;
      if (acc_write) mod_d[acc_frame] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q        <= '0;
      mod_q        <= '0;
      lfsr_q       <= LFSR_SEED;
      victim_valid <= 1'b0;
      victim_frame <= '0;
      victim_class <= 2'd0;
    end else begin
      ref_q        <= ref_d;
      mod_q        <= mod_d;
      lfsr_q       <= {lfsr_q[14:0], lfsr_fb};
      victim_valid <= victim_req;
      if (victim_req) begin
        victim_frame <= pick;
        victim_class <= low_cls;
      end
    end
  end

endmodule

module nru_victim_sel_chk #(
  parameter int NFRAMES = 8,
  parameter int IW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [IW-1:0]      acc_frame,
  input logic               acc_write,
  input logic               tick,
  input logic               victim_req,
  input logic [IW-1:0]      victim_frame,
  input logic [1:0]         victim_class,
  input logic               victim_valid,
  input logic [NFRAMES-1:0] ref_q,
  input logic [NFRAMES-1:0] mod_q,
  input logic [15:0]        lfsr_q
);

  logic               armed_q, req_p;
  logic [NFRAMES-1:0] ref_p, mod_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      req_p   <= 1'b0;
      ref_p   <= '0;
      mod_p   <= '0;
    end else begin
      armed_q <= 1'b1;
      req_p   <= victim_req;
      ref_p   <= ref_q;
      mod_p   <= mod_q;
    end
  end

  // R8
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> victim_valid == req_p);

  // R4
  class_matches_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && victim_valid |-> victim_class == {ref_p[victim_frame], mod_p[victim_frame]});

  // R5
  no_lower_class0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && victim_valid && victim_class != 2'd0 |-> (~ref_p & ~mod_p) == '0);

  // R5
  no_lower_class1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && victim_valid && victim_class[1] |-> &ref_p);

  // R5
  no_lower_class2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && victim_valid && victim_class == 2'd3 |-> &mod_p);

  // R2
  access_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_q[$past(acc_frame)]);

  // R2
  write_sets_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> mod_q[$past(acc_frame)]);

  // R3
  tick_clears_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !acc_valid |=> ref_q == '0);

  // R3
  tick_keeps_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !acc_valid |=> mod_q == $past(mod_q));

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);

endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NFRAMES(NFRAMES), .IW(IW)) u_chk (.*);

// File: tb/nru_victim_sel_tb.sv
`timescale 1ns/1ps
module nru_victim_sel_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, tick = 1'b0, victim_req = 1'b0;
  logic [2:0] acc_frame = 3'd0;
  logic [2:0] victim_frame;
  logic [1:0] victim_class;
  logic       victim_valid;

  always #10 clk = ~clk;

  nru_victim_sel u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_write(acc_write), .tick(tick), .victim_req(victim_req),
    .victim_frame(victim_frame), .victim_class(victim_class), .victim_valid(victim_valid)
  );

  int    n_checks = 0, n_fail = 0;
  bit    done = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit mr[8], mm[8];
  int ml;
  int e_valid, e_frame, e_class;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mr[i]) begin mr[i] = 0; mm[i] = 0; end
      ml = 16'hACE1; e_valid = 0; e_frame = 0; e_class = 0;
    end else begin
      e_valid = victim_req;
      if (victim_req) begin
        int mn, st;
        bit got;
        mn = 3; got = 0;
        for (int f = 0; f < 8; f++) if (2*mr[f] + mm[f] < mn) mn = 2*mr[f] + mm[f];
        st = ml % 8;
        for (int k = 0; k < 8; k++) begin
          int idx;
          idx = (st + k) % 8;
          if (!got && (2*mr[idx] + mm[idx] == mn)) begin got = 1; e_frame = idx; end
        end
        e_class = mn;
      end
      if (tick) foreach (mr[i]) mr[i] = 0;
      if (acc_valid) begin
        mr[acc_frame] = 1;
        if (acc_write) mm[acc_frame] = 1;
      end
      ml = ((ml << 1) | (((ml >> 15) ^ (ml >> 13) ^ (ml >> 12) ^ (ml >> 10)) & 1)) & 16'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(victim_valid == e_valid, {phase, " R8 valid"}, victim_valid, e_valid);
      check(victim_frame == e_frame, {phase, " R6 frame"}, victim_frame, e_frame);
      check(victim_class == e_class, {phase, " R4 class"}, victim_class, e_class);
    end
  end

  task automatic drive(input bit av, input int f, input bit w, input bit tk, input bit rq);
    acc_valid = av; acc_frame = 3'(f); acc_write = w; tick = tk; victim_req = rq;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; tick = 0; victim_req = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(victim_valid == 0, "R1 valid in reset", victim_valid, 0);
    check(victim_class == 0, "R1 class in reset", victim_class, 0);
    do_reset();
    phase = "R1";
    drive(0, 0, 0, 0, 1);
    check(victim_class == 0, "R1 class after reset", victim_class, 0);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);

    phase = "R2";
    for (int f = 0; f < 8; f++) drive(1, f, 0, 0, 0);
    drive(1, 2, 1, 0, 0);
    drive(0, 0, 0, 0, 1);
    check(victim_class == 2, "R2 read leaves clean", victim_class, 2);
    check(victim_frame != 2, "R2 written frame skipped", victim_frame, 2);

    phase = "R3";
    for (int f = 0; f < 8; f++) drive(1, f, 1, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    check(victim_class == 1, "R3 tick keeps written bit", victim_class, 1);

    phase = "R5";
    do_reset();
    for (int f = 0; f < 8; f++) if (f != 5) drive(1, f, 1, 0, 0);
    drive(1, 5, 0, 0, 0);
    for (int r = 0; r < 4; r++) begin
      drive(0, 0, 0, 0, 1);
      check(victim_frame == 5, "R5 lone lower class", victim_frame, 5);
      check(victim_class == 2, "R5 lone lower class", victim_class, 2);
    end

    phase = "R7";
    for (int f = 0; f < 8; f++) drive(1, f, 1, 0, 0);
    drive(1, 3, 0, 1, 0);
    for (int f = 0; f < 8; f++) if (f != 3) drive(1, f, 1, 0, 0);
    drive(0, 0, 0, 0, 1);
    check(victim_class == 3, "R7 access after tick", victim_class, 3);

    phase = "R9";
    do_reset();
    for (int f = 0; f < 8; f++) if (f != 6) drive(1, f, 0, 0, 0);
    drive(1, 6, 1, 0, 1);
    check(victim_frame == 6, "R9 pre-access state", victim_frame, 6);
    check(victim_class == 0, "R9 pre-access state", victim_class, 0);

    phase = "R8";
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    check(victim_valid == 0, "R8 single pulse", victim_valid, 0);

    phase = "R6";
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      drive(r[0] | r[1], r[6:4], r[2], (r[11:8] == 0), r[3]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule